// File: doc/BRIEF.md
# Partitioned SIMD Saturating Adder

This block is a purely combinational 64-bit add/subtract unit for packed media data. A single 64-bit datapath is cut into independent lanes at run time: eight byte lanes, four halfword lanes or two word lanes. In every lane, the two operands are treated as signed two's-complement values of that lane's width. No carry and no borrow cross a lane boundary.

Each lane can either wrap its result modulo its width or clamp it. When clamping is selected, an overflowing lane gives the extreme value of its own width that matches the direction of the overflow. The other lanes keep their exact results. A per-byte flag vector reports which lanes overflowed, in both modes. A datapath stage can use it to apply clipping to packed audio or pixel data in a single pass.

Top module: `simd_sat_addsub`

## Requirements
- R1: `mode_i` sets the lane layout. 0 gives eight 8-bit lanes, 1 gives four 16-bit lanes and 2 gives two 32-bit lanes. 3 behaves exactly like 0. Lane j of width w occupies bits [j*w+w-1 : j*w].
- R2: When `sub_i`=0, each lane outputs (a+b) mod 2^w. The carry out of a lane's top bit never reaches the next lane.
- R3: When `sub_i`=1, each lane outputs (a + ~b + 1) mod 2^w, which is a-b. The +1 is applied per lane, and no borrow crosses a lane boundary.
- R4: For an addition, a lane overflows only when both operand signs are equal and the result sign differs from them. Operands with opposite signs never overflow.
- R5: For a subtraction, a lane overflows only when the operand signs differ and the result sign differs from the sign of a. Operands with equal signs never overflow.
- R6: When `sat_i`=1, an overflowing lane outputs its maximum positive value 0x7F..F if a is non-negative. It outputs its minimum negative value 0x80..0 if a is negative.
- R7: When `sat_i`=0, overflowing lanes wrap. In both modes, lanes without overflow give the exact wrapped sum or difference.
- R8: `ovf_o` bit k belongs to byte k (bits [8k+7:8k]). It is 1 exactly when the lane that contains byte k overflowed, so all the bits of one lane are equal. It is reported whatever the value of `sat_i`.
- R9: The outputs depend only on the present inputs. There are no state or clock stages.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 64 | Packed first operand |
| b_i | input | 64 | Packed second operand |
| mode_i | input | 2 | Lane layout: 0 byte, 1 halfword, 2 word, 3 byte |
| sub_i | input | 1 | 0 add, 1 subtract (a - b) |
| sat_i | input | 1 | 1 clamps overflowing lanes, 0 wraps them |
| res_o | output | 64 | Packed per-lane result |
| ovf_o | output | 8 | Per-byte overflow flags, replicated across each lane |

## Verification
Every result is due in the same cycle as its stimulus, because no register lies between the inputs and `res_o` or `ovf_o`. The driver applies each operand set at a rising edge and queues the values it expects. The monitor compares the outputs at the following falling edge, half a period later, so the logic has settled and no check races the drive. The expected values come from a signed-integer model in the bench that handles each lane width separately.

// File: rtl/simd_sat_pkg.sv
package simd_sat_pkg;
  localparam int unsigned WORD_W = 64;
  localparam int unsigned SEG_W  = 8;
  localparam int unsigned N_SEG  = WORD_W / SEG_W;
  localparam int unsigned IDX_W  = $clog2(N_SEG);

  typedef enum logic [1:0] {
    LANE_B8   = 2'd0,
    LANE_H16  = 2'd1,
    LANE_W32  = 2'd2,
    LANE_RSVD = 2'd3
  } lane_mode_e;
endpackage

// File: rtl/simd_lane_map.sv
module simd_lane_map
  import simd_sat_pkg::*;
#(
  parameter int unsigned NSEG = N_SEG,
  localparam int unsigned IW  = $clog2(NSEG)
) (
  input  lane_mode_e       mode_i,
  output logic [NSEG-1:0]  head_o,
  output logic [NSEG-1:0]  tail_o,
  output logic [IW-1:0]    span_m1_o
);
  logic [IW-1:0] span;

  always_comb begin
    unique case (mode_i)
      LANE_H16: span = IW'(2);
      LANE_W32: span = IW'(4);
      default:  span = IW'(1);
    endcase
    span_m1_o = span - IW'(1);
    for (int k = 0; k < int'(NSEG); k++) begin
      head_o[k] = ((IW'(k) & span_m1_o) == '0);
      tail_o[k] = ((IW'(k) & span_m1_o) == span_m1_o);
    end
  end

  // R1: lane starts follow lane ends, lane count matches the layout
  always_comb begin
    a_r1_head_after_tail: assert (head_o == {tail_o[NSEG-2:0], 1'b1});
    a_r1_lane_count: assert (($countones(head_o) * int'(span)) == int'(NSEG));
  end
endmodule

// File: rtl/simd_seg_adder.sv
module simd_seg_adder #(
  parameter int unsigned SW = 8
) (
  input  logic [SW-1:0] a_i,
  input  logic [SW-1:0] b_i,
  input  logic          c_i,
  output logic [SW-1:0] s_o,
  output logic          c_o
);
  logic [SW:0] full;

  always_comb begin
    full = {1'b0, a_i} + {1'b0, b_i} + {{SW{1'b0}}, c_i};
    s_o  = full[SW-1:0];
    c_o  = full[SW];
  end
endmodule

// File: rtl/simd_seg_sat.sv
module simd_seg_sat #(
  parameter int unsigned SW = 8
) (
  input  logic [SW-1:0] raw_i,
  input  logic          is_tail_i,
  input  logic          lane_ovf_i,
  input  logic          neg_i,
  input  logic          sat_i,
  output logic [SW-1:0] res_o
);
  always_comb begin
    if (sat_i && lane_ovf_i)
      res_o = is_tail_i ? {neg_i, {(SW-1){~neg_i}}} : {SW{~neg_i}};
    else
      res_o = raw_i;
  end

  // R6: a clamped segment never keeps a wrapped value that differs from the clamp pattern
  always_comb begin
    if (sat_i && lane_ovf_i && is_tail_i)
      a_r6_tail_sign: assert (res_o[SW-1] == neg_i);
    if (!(sat_i && lane_ovf_i))
      a_r7_pass_through: assert (res_o == raw_i);
  end
endmodule

// File: rtl/simd_sat_addsub.sv
module simd_sat_addsub
  import simd_sat_pkg::*;
#(
  parameter int unsigned DW = WORD_W,
  parameter int unsigned SW = SEG_W,
  localparam int unsigned NS = DW / SW,
  localparam int unsigned IW = $clog2(NS)
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [1:0]    mode_i,
  input  logic          sub_i,
  input  logic          sat_i,
  output logic [DW-1:0] res_o,
  output logic [NS-1:0] ovf_o
);
  logic [NS-1:0] head, tail, ovf_tail;
  logic [IW-1:0] span_m1;
  logic [DW-1:0] b_eff, raw;

  assign b_eff = b_i ^ {DW{sub_i}};

  simd_lane_map #(.NSEG(NS)) u_map (
    .mode_i   (lane_mode_e'(mode_i)),
    .head_o   (head),
    .tail_o   (tail),
    .span_m1_o(span_m1)
  );

  for (genvar k = 0; k < int'(NS); k++) begin : g_seg
    logic          c_in, c_out;
    logic [SW-1:0] sum;
    logic          a_s, b_s;
    logic [IW-1:0] tidx;
    logic          neg;

    if (k == 0) begin : g_first
      assign c_in = sub_i;
    end else begin : g_chain
      // lane head restarts the chain with the negation's +1
      assign c_in = head[k] ? sub_i : g_seg[k-1].c_out;
    end

    simd_seg_adder #(.SW(SW)) u_add (
      .a_i(a_i[k*SW +: SW]),
      .b_i(b_eff[k*SW +: SW]),
      .c_i(c_in),
      .s_o(sum),
      .c_o(c_out)
    );

    assign a_s         = a_i[k*SW + SW - 1];
    assign b_s         = b_eff[k*SW + SW - 1];
    assign ovf_tail[k] = tail[k] & (a_s == b_s) & (sum[SW-1] != a_s);
    assign raw[k*SW +: SW] = sum;

    assign tidx     = IW'(k) | span_m1;
    assign ovf_o[k] = ovf_tail[tidx];
    assign neg      = a_i[int'(tidx)*SW + SW - 1];

    simd_seg_sat #(.SW(SW)) u_sat (
      .raw_i     (sum),
      .is_tail_i (tail[k]),
      .lane_ovf_i(ovf_o[k]),
      .neg_i     (neg),
      .sat_i     (sat_i),
      .res_o     (res_o[k*SW +: SW])
    );
  end

  always_comb begin
    // R4: opposite-sign addition in the top lane never overflows
    if (!sub_i && (a_i[DW-1] != b_i[DW-1]))
      a_r4_no_overflow: assert (!ovf_o[NS-1]);
    // R5: equal-sign subtraction in the top lane never overflows
    if (sub_i && (a_i[DW-1] == b_i[DW-1]))
      a_r5_no_overflow: assert (!ovf_o[NS-1]);
    // R2: byte layout, plain add, wrap: each byte is the 8-bit sum
    if ((mode_i == 2'd0) && !sub_i && !sat_i)
      for (int j = 0; j < int'(NS); j++)
        a_r2_byte_wrap: assert (res_o[j*SW +: SW] == SW'(a_i[j*SW +: SW] + b_i[j*SW +: SW]));
    // R8: flags equal within a halfword lane
    if (mode_i == 2'd1)
      for (int j = 0; j < int'(NS); j += 2)
        a_r8_flag_replicated: assert (ovf_o[j] == ovf_o[j+1]);
  end
endmodule

// File: tb/tb_simd_sat_addsub.sv
module tb_simd_sat_addsub;
  localparam time CLK_P = 8ns;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] a, b, res;
  logic [1:0]  mode;
  logic        sub, sat;
  logic [7:0]  ovf;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [63:0] a, b, r;
    logic [7:0]  o;
    logic [1:0]  m;
    logic        s, t;
    string       tag;
  } item_t;
  item_t q[$];

  always #(CLK_P/2) clk = ~clk;

  simd_sat_addsub dut (
    .a_i(a), .b_i(b), .mode_i(mode), .sub_i(sub), .sat_i(sat),
    .res_o(res), .ovf_o(ovf)
  );

  function automatic void model(input logic [63:0] fa, fb, input logic [1:0] fm,
                                input logic fs, ft,
                                output logic [63:0] fr, output logic [7:0] fo);
    int w, n;
    w = (fm == 2'd1) ? 16 : (fm == 2'd2) ? 32 : 8;
    n = 64 / w;
    fr = '0;
    fo = '0;
    for (int l = 0; l < n; l++) begin
      longint av, bv, sm, mx, mn, full;
      logic [63:0] msk;
      logic ov;
      full = longint'(1) << w;
      msk  = 64'(full - 1);
      av = longint'((fa >> (l*w)) & msk);
      bv = longint'((fb >> (l*w)) & msk);
      if (av >= (full >>> 1)) av = av - full;
      if (bv >= (full >>> 1)) bv = bv - full;
      sm = fs ? (av - bv) : (av + bv);
      mx = (full >>> 1) - 1;
      mn = -(full >>> 1);
      ov = (sm > mx) || (sm < mn);
      if (ov && ft) sm = (sm > mx) ? mx : mn;
      fr = fr | ((64'(sm) & msk) << (l*w));
      if (ov)
        for (int k = 0; k < w/8; k++) fo[l*(w/8) + k] = 1'b1;
    end
  endfunction

  task automatic drive(input logic [63:0] da, db, input logic [1:0] dm,
                       input logic ds, dt, input string tag);
    item_t it;
    @(posedge clk);
    a = da; b = db; mode = dm; sub = ds; sat = dt;
    it.a = da; it.b = db; it.m = dm; it.s = ds; it.t = dt; it.tag = tag;
    model(da, db, dm, ds, dt, it.r, it.o);
    q.push_back(it);
  endtask

  // monitor: combinational results are due half a cycle after the drive
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if (res !== it.r || ovf !== it.o) begin
          errors++;
          $display("FAIL %s a=%h b=%h m=%0d s=%0b t=%0b res=%h ovf=%b expected res=%h ovf=%b",
                   it.tag, it.a, it.b, it.m, it.s, it.t, res, ovf, it.r, it.o);
        end
      end
    end
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [63:0] x;
    a = '0; b = '0; mode = '0; sub = 1'b0; sat = 1'b0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;

    // R9: idle zero inputs give zero outputs with no clocked state
    drive(64'h0, 64'h0, 2'd0, 1'b0, 1'b0, "R9 zero");
    // R2: byte carries do not cross lanes
    drive(64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 2'd0, 1'b0, 1'b0, "R2 byte carry cut");
    // R1: same data across the layouts
    drive(64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 2'd1, 1'b0, 1'b0, "R1 halfword");
    drive(64'hFFFF_FFFF_0000_FFFF, 64'h0000_0001_0000_0001, 2'd2, 1'b0, 1'b0, "R1 word");
    drive(64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 2'd3, 1'b0, 1'b0, "R1 mode3 as byte");
    // R3: per-lane subtraction without borrow crossing
    drive(64'h0, 64'h0101_0101_0101_0101, 2'd0, 1'b1, 1'b0, "R3 byte sub");
    drive(64'h0000_0000_0001_0000, 64'h0000_0000_0000_0001, 2'd1, 1'b1, 1'b0, "R3 halfword borrow cut");
    // R4: add overflow both directions
    drive(64'h7F, 64'h01, 2'd0, 1'b0, 1'b0, "R4 pos wrap");
    drive(64'h7F, 64'h01, 2'd0, 1'b0, 1'b1, "R4 pos sat");
    drive(64'h80, 64'hFF, 2'd0, 1'b0, 1'b1, "R4 neg sat");
    drive(64'h7F, 64'h80, 2'd0, 1'b0, 1'b1, "R4 mixed signs");
    // R5: subtract overflow both directions
    drive(64'h7F, 64'hFF, 2'd0, 1'b1, 1'b1, "R5 pos sat");
    drive(64'h80, 64'h01, 2'd0, 1'b1, 1'b1, "R5 neg sat");
    drive(64'h80, 64'h80, 2'd0, 1'b1, 1'b1, "R5 equal signs");
    // R6: clamps at wider lanes
    drive(64'h7FFF_0000_0000_7FFF, 64'h0001_0000_0000_0001, 2'd1, 1'b0, 1'b1, "R6 halfword max");
    drive(64'h8000_0000_0000_0000, 64'h0000_0001_0000_0000, 2'd2, 1'b1, 1'b1, "R6 word min");
    // R7: only overflowing lanes change under saturation
    drive(64'h7F10_8020_3040_5060, 64'h0101_FF01_0101_0101, 2'd0, 1'b0, 1'b1, "R7 mixed lanes sat");
    drive(64'h7F10_8020_3040_5060, 64'h0101_FF01_0101_0101, 2'd0, 1'b0, 1'b0, "R7 mixed lanes wrap");
    // R8: flags replicated over lane bytes, both modes
    drive(64'h7FFF_0000_8000_0000, 64'h0001_0000_FFFF_0000, 2'd1, 1'b0, 1'b0, "R8 halfword flags");
    drive(64'h7FFF_FFFF_0000_0000, 64'h0000_0001_0000_0000, 2'd2, 1'b0, 1'b1, "R8 word flags");

    x = 64'h9E37_79B9_7F4A_7C15;
    for (int i = 0; i < 400; i++) begin
      logic [63:0] ra, rb;
      x = x ^ (x << 13); x = x ^ (x >> 7); x = x ^ (x << 17);
      ra = x;
      x = x ^ (x << 13); x = x ^ (x >> 7); x = x ^ (x << 17);
      rb = x;
      drive(ra, rb, 2'(i), x[20], x[41], "R2 R3 R4 R5 R6 R7 R8 sweep");
    end

    repeat (3) @(posedge clk);
    done = 1;
    finish_run();
  end
endmodule